// File: doc/BRIEF.md
# Serial-accessed RTC seconds counter

This block is the timekeeping end of a slow serial link. It keeps a 32-bit count of whole seconds, advanced by a prescaler that divides a single-cycle oscillator tick strobe, and a bank of eight 32-bit registers selected by a 3-bit address. The seconds counter is one of those registers. A host reaches all of them over five wires: an enable level, a serial clock, a data input, a data output and a ready flag. The host can also request that the ready flag be re-armed.

A transfer starts when enable rises. While enable is high, each rising serial clock edge shifts one bit in, MSB first. A write sends 32 data bits and then 3 address bits. A read sends only the 3 address bits. The host then lowers enable and gives one more clock pulse. This is the mode frame, and the level on data-in at that pulse decides the direction. For a read, the following pulses bring the selected register out on data-out, one bit per pulse, MSB first. All link inputs are asynchronous to the register clock. Each one passes through a two-flop synchronizer before its edges are detected.

Top module: `sec_link_rtc`

## Requirements
- R1: While reset is held and just after it is released, `ser_dout` is 0, `ser_ready` is 0, and every register reads back as 0.
- R2: After reset is released, `ser_ready` goes high after exactly READY_DELAY clock edges. It then stays high until a re-arm request arrives.
- R3: A rising edge on `rdy_rearm` pulls `ser_ready` low on the third clock edge after the pin changes. `ser_ready` goes high again READY_DELAY edges later.
- R4: A write frame updates the addressed register. The frame is 32 data bits followed by 3 address bits, MSB first, shifted in on serial clock rises while enable is high. It is followed by a serial clock rise with enable low and data-in = 1. A later write to the same address replaces the earlier value.
- R5: A read works as follows. The host sends 3 address bits, then a serial clock rise with enable low and data-in = 0. Each of the next 32 serial clock pulses then drives the next bit of the addressed register on `ser_dout`. The first pulse gives bit 31 and the last gives bit 0.
- R6: The seconds register sits at address SEC_ADDR (default 0). It increments by one on every TICKS_PER_SEC-th `osc_tick` strobe.
- R7: A write to the seconds register also restarts the prescaler. The next increment therefore needs a full TICKS_PER_SEC ticks counted after the write.
- R8: A rise of enable discards any bits shifted in so far. A write mode pulse that follows fewer than 35 data and address bits leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Single-cycle oscillator tick strobe, synchronous to clk |
| ser_en | input | 1 | Link enable level; a rise starts a frame |
| ser_clk | input | 1 | Link serial clock; its rising edges are counted |
| ser_din | input | 1 | Link serial data in |
| ser_dout | output | 1 | Link serial data out for reads |
| ser_ready | output | 1 | Link ready flag |
| rdy_rearm | input | 1 | Host request to re-arm the ready flag (rising edge) |

## Verification
Every link input takes two synchronizer edges plus one edge-detect edge. A shifted bit, the mode decision and each read bit on `ser_dout` therefore settle three clock edges after the pin changes, and a write lands in its register one edge after that. The bench holds each serial phase for four clock cycles and samples at negative edges, so each result is read after it has settled and before the next pin change. The ready flag is checked on the exact edges that R2 and R3 give, both one edge before the rise and on the edge of the rise. Oscillator ticks are counted so that the edge of a seconds increment is known.

// File: rtl/sec_link_pkg.sv
package sec_link_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int FRAME_W  = DATA_W + ADDR_W;
  localparam int NUM_REGS = 1 << ADDR_W;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;

  // Data part of a write frame: the bits shifted in before the address.
  function automatic logic [DATA_W-1:0] frame_data(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1:ADDR_W];
  endfunction

  // Address part: the last ADDR_W bits shifted in.
  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] f);
    return f[ADDR_W-1:0];
  endfunction

  // True when the prescaler value is the last one before a seconds step.
  function automatic logic presc_at_limit(input int unsigned p, input int unsigned lim);
    return p == lim - 1;
  endfunction

  function automatic logic [DATA_W-1:0] sec_advance(input logic [DATA_W-1:0] s);
    return s + 1'b1;
  endfunction
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sl_ready_ctl.sv
module sl_ready_ctl #(
  parameter int READY_DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm_s,
  output logic ready
);
  localparam int CW = (READY_DELAY > 1) ? $clog2(READY_DELAY) : 1;

  logic          rearm_d;
  logic [CW-1:0] cnt;
  logic          rearm_evt;

  assign rearm_evt = rearm_s & ~rearm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rearm_d <= 1'b0;
      cnt     <= '0;
      ready   <= 1'b0;
    end else begin
      rearm_d <= rearm_s;
      if (rearm_evt) begin
        ready <= 1'b0;
        cnt   <= '0;
      end else if (!ready) begin
        if (cnt == CW'(READY_DELAY - 1)) ready <= 1'b1;
        else                             cnt   <= cnt + 1'b1;
      end
    end
  end

  // R3: a re-arm request always drops the flag on the next edge
  assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_evt |=> !ready);
  // R2: once high, the flag holds until a re-arm request
  assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !rearm_evt) |=> ready);
endmodule

// File: rtl/sl_frame_rx.sv
module sl_frame_rx
  import sec_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output wr_req_t           wr,
  output logic              dout
);
  localparam int CNTW = $clog2(FRAME_W + 1);

  logic              en_d, sclk_d;
  logic [FRAME_W-1:0] sh;
  logic [CNTW-1:0]   bit_cnt;
  logic              rd_active;
  logic [CNTW-1:0]   rd_left;
  logic [DATA_W-1:0] rd_sh;

  // named events
  logic en_rise, sclk_rise, load_bit, mode_evt, rd_step, write_evt, read_evt;

  assign en_rise   = en_s & ~en_d;
  assign sclk_rise = sclk_s & ~sclk_d & ~en_rise;
  assign load_bit  = sclk_rise & en_s & ~rd_active;
  assign mode_evt  = sclk_rise & ~en_s & ~rd_active;
  assign rd_step   = sclk_rise & rd_active;
  assign write_evt = mode_evt & din_s & (bit_cnt == CNTW'(FRAME_W));
  assign read_evt  = mode_evt & ~din_s & (bit_cnt >= CNTW'(ADDR_W));

  assign rd_addr = frame_addr(sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      en_d   <= en_s;
      sclk_d <= sclk_s;
    end
  end

  // inbound shifting and frame clearing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (en_rise) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (load_bit) begin
      sh <= {sh[FRAME_W-2:0], din_s};
      if (bit_cnt != CNTW'(FRAME_W)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // write commit request, one cycle wide
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr <= '0;
    end else begin
      wr.vld <= write_evt;
      if (write_evt) begin
        wr.addr <= frame_addr(sh);
        wr.data <= frame_data(sh);
      end
    end
  end

  // outbound read shifting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_left   <= '0;
      rd_sh     <= '0;
      dout      <= 1'b0;
    end else if (en_rise) begin
      rd_active <= 1'b0;
      rd_left   <= '0;
    end else if (read_evt) begin
      rd_active <= 1'b1;
      rd_left   <= CNTW'(DATA_W);
      rd_sh     <= rd_data;
    end else if (rd_step) begin
      dout      <= rd_sh[DATA_W-1];
      rd_sh     <= {rd_sh[DATA_W-2:0], 1'b0};
      rd_left   <= rd_left - 1'b1;
      rd_active <= (rd_left != CNTW'(1));
    end
  end

  // R8: every frame begins from an empty state
  assert_frame_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (bit_cnt == '0 && !rd_active));
  // R4: a commit request lasts exactly one cycle
  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr.vld |=> !wr.vld);
  // R5: a read never outlives its 32 data pulses
  assert_rd_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> (rd_left <= CNTW'(DATA_W) && rd_left != '0));
endmodule

// File: rtl/sl_reg_bank.sv
module sl_reg_bank
  import sec_link_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SEC_ADDR      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  wr_req_t           wr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic wr_hit;
    assign wr_hit = wr.vld && (wr.addr == ADDR_W'(i));

    if (i == SEC_ADDR) begin : g_sec
      logic [PW-1:0]     presc;
      logic [DATA_W-1:0] sec_q;
      logic              tick_wrap;

      assign tick_wrap = osc_tick && presc_at_limit(int'(presc), TICKS_PER_SEC);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          presc <= '0;
          sec_q <= '0;
        end else if (wr_hit) begin
          presc <= '0;
          sec_q <= wr.data;
        end else if (osc_tick) begin
          if (tick_wrap) begin
            presc <= '0;
            sec_q <= sec_advance(sec_q);
          end else begin
            presc <= presc + 1'b1;
          end
        end
      end
      assign reg_q[i] = sec_q;

      // R6: seconds move only on a prescaler wrap, by exactly one
      assert_sec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !tick_wrap) |=> $stable(sec_q));
      assert_sec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_wrap && !wr_hit) |=> sec_q == $past(sec_q) + 1'b1);
      // R7: a seconds write restarts the prescaler
      assert_presc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (presc == '0 && sec_q == $past(wr.data)));
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (wr_hit) q <= wr.data;
      end
      assign reg_q[i] = q;
    end
  end

  assign rd_data = reg_q[rd_addr];
endmodule

// File: rtl/sec_link_rtc.sv
module sec_link_rtc
  import sec_link_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int READY_DELAY   = 16,
  parameter int SEC_ADDR      = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic ser_en,
  input  logic ser_clk,
  input  logic ser_din,
  output logic ser_dout,
  output logic ser_ready,
  input  logic rdy_rearm
);
  logic [3:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  wr_req_t           wr;

  sl_sync #(.W(4)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rdy_rearm, ser_din, ser_clk, ser_en}),
    .q     (pins_s)
  );

  sl_frame_rx u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_s    (pins_s[0]),
    .sclk_s  (pins_s[1]),
    .din_s   (pins_s[2]),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr      (wr),
    .dout    (ser_dout)
  );

  sl_reg_bank #(.TICKS_PER_SEC(TICKS_PER_SEC), .SEC_ADDR(SEC_ADDR)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .wr       (wr),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  sl_ready_ctl #(.READY_DELAY(READY_DELAY)) u_ready (
    .clk     (clk),
    .rst_n   (rst_n),
    .rearm_s (pins_s[3]),
    .ready   (ser_ready)
  );
endmodule

// File: tb/sec_link_rtc_tb_top.sv
module sec_link_rtc_tb_top;
  localparam int TICKS = 8;
  localparam int RDY_D = 16;
  localparam int NVEC  = 7;
  // {address, data}
  localparam logic [34:0] VEC [NVEC] = '{
    {3'd1, 32'hDEAD_BEEF}, {3'd2, 32'h0000_0001}, {3'd3, 32'h8000_0000},
    {3'd5, 32'h1234_5678}, {3'd7, 32'hFFFF_FFFF}, {3'd5, 32'hA5A5_5A5A},
    {3'd6, 32'h0F0F_F0F0}
  };

  logic clk = 0, rst_n = 0, osc_tick = 0;
  logic ser_en = 0, ser_clk = 0, ser_din = 0, rdy_rearm = 0;
  logic ser_dout, ser_ready;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_mem [8];

  always #10 clk = ~clk;

  sec_link_rtc #(.TICKS_PER_SEC(TICKS), .READY_DELAY(RDY_D), .SEC_ADDR(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ser_en(ser_en),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_dout(ser_dout),
    .ser_ready(ser_ready), .rdy_rearm(rdy_rearm));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_din = b; wait_n(4);
    ser_clk = 1; wait_n(4);
    ser_clk = 0; wait_n(4);
  endtask

  task automatic begin_frame();
    ser_en = 0; wait_n(4);
    ser_en = 1; wait_n(4);
  endtask

  task automatic mode_bit(input logic b);
    ser_en = 0; wait_n(4);
    send_bit(b);
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
    begin_frame();
    for (int i = 31; i >= 0; i--) send_bit(d[i]);
    for (int i = 2; i >= 0; i--) send_bit(a[i]);
    mode_bit(1'b1);
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [31:0] v);
    begin_frame();
    for (int i = 2; i >= 0; i--) send_bit(a[i]);
    mode_bit(1'b0);
    v = '0;
    for (int i = 31; i >= 0; i--) begin
      ser_din = 0; wait_n(4);
      ser_clk = 1; wait_n(4);
      v[i] = ser_dout;
      ser_clk = 0; wait_n(4);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1; wait_n(1);
      osc_tick = 0; wait_n(1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 8; i++) exp_mem[i] = '0;
    wait_n(3);
    chk("R1 dout in reset", {31'd0, ser_dout}, 32'd0);
    chk("R1 ready in reset", {31'd0, ser_ready}, 32'd0);
    rst_n = 1;
    // R2: exact rise edge after reset
    wait_n(RDY_D - 1);
    chk("R2 ready before delay", {31'd0, ser_ready}, 32'd0);
    wait_n(1);
    chk("R2 ready at delay", {31'd0, ser_ready}, 32'd1);
    // R1: registers start at zero
    read_reg(3'd3, v);
    chk("R1 reg3 after reset", v, 32'd0);
    read_reg(3'd0, v);
    chk("R1 seconds after reset", v, 32'd0);

    // table walk: R4 writes, R5 reads
    for (int k = 0; k < NVEC; k++) begin
      write_reg(VEC[k][34:32], VEC[k][31:0]);
      exp_mem[VEC[k][34:32]] = VEC[k][31:0];
    end
    for (int a = 1; a < 8; a++) begin
      read_reg(3'(a), v);
      chk($sformatf("R4 R5 readback addr %0d", a), v, exp_mem[a]);
    end
    chk("R2 ready held", {31'd0, ser_ready}, 32'd1);

    // R8: discarded partial bits and a short write frame
    begin_frame();
    for (int i = 0; i < 30; i++) send_bit(1'b1);
    begin_frame();
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    mode_bit(1'b1);
    read_reg(3'd2, v);
    chk("R8 short write ignored", v, exp_mem[2]);
    read_reg(3'd7, v);
    chk("R8 no stray write to addr 7", v, exp_mem[7]);

    // R6 / R7: prescaler restart on write
    tick(5);
    write_reg(3'd0, 32'h0000_0100);
    tick(TICKS - 1);
    read_reg(3'd0, v);
    chk("R7 no step before full period", v, 32'h0000_0100);
    tick(1);
    read_reg(3'd0, v);
    chk("R6 step after full period", v, 32'h0000_0101);
    tick(TICKS);
    read_reg(3'd0, v);
    chk("R6 second step", v, 32'h0000_0102);
    write_reg(3'd0, 32'hFFFF_FFFF);
    tick(TICKS);
    read_reg(3'd0, v);
    chk("R6 counter wraps", v, 32'h0000_0000);

    // R3: re-arm request
    rdy_rearm = 1;
    wait_n(2);
    chk("R3 ready before drop", {31'd0, ser_ready}, 32'd1);
    wait_n(1);
    chk("R3 ready dropped", {31'd0, ser_ready}, 32'd0);
    wait_n(RDY_D - 1);
    chk("R3 ready still low", {31'd0, ser_ready}, 32'd0);
    wait_n(1);
    chk("R3 ready restored", {31'd0, ser_ready}, 32'd1);
    rdy_rearm = 0;
    wait_n(10);
    chk("R3 release has no effect", {31'd0, ser_ready}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule